// File: doc/BRIEF.md
# Synchronized Clock Stop Controller

This block sits between a set of free-running source clocks and the clock pins of a board-level clock generator. It gates a group of processor clocks, a group of bus clocks and a group of auxiliary clocks. It also drives one bus reference clock that keeps running while the bus group is stopped. Three active-low requests control the gating: a processor stop, a bus stop and a power-down. Each request is brought into the bus source domain through a synchronizer. It is then qualified on a rising edge of the bus source clock. The gated output applies it only on the next falling edge of its own source clock. Because of this, an output always stops low and never emits a shortened high phase.

Power-down overrides both stop requests and drives every output low, including the reference clock. When power-down is released, or when reset ends, a counter clocked by an always-on oscillator holds all outputs low for a fixed number of oscillator cycles. This models the settling time of the clock sources. Only after that count do the outputs resume.

Top module: `clk_stop_ctrl`

## Requirements
- R1: While `rst_n` is low, every output (`cpu_clk_o`, `bus_clk_o`, `bus_ref_o`, `aux_clk_o`) is low.
- R2: A gated output is never high while its source is low. Every high pulse on an output lasts exactly one full high phase of its source. All bits of one group carry the same waveform.
- R3: With `cpu_stop_n` low, all `cpu_clk_o` bits stop low. The stop takes effect on the first falling edge of `cpu_src_clk` after SYNC_STAGES+1 rising edges of `bus_src_clk` that follow the request. Until those edges have passed, the outputs keep running. Release restarts the outputs with the same timing.
- R4: With `bus_stop_n` low, all `bus_clk_o` bits stop low. This takes effect on the first falling edge of `bus_src_clk` after SYNC_STAGES+1 rising edges of it, and release restarts them with the same timing.
- R5: `cpu_stop_n` has no effect on the bus, reference or auxiliary outputs. `bus_stop_n` has no effect on the processor, reference or auxiliary outputs. In particular, `bus_ref_o` keeps running while the bus group is stopped.
- R6: With `pd_n` low, every output, including `bus_ref_o` and `aux_clk_o`, goes low and stays low, even when both stop requests are high.
- R7: After `pd_n` goes high, or after reset is released with `pd_n` high, all outputs stay low for at least PWRUP_CYCLES cycles of `osc_clk`. After that they run again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| osc_clk | input | 1 | Always-on oscillator clock for the power-up counter |
| rst_n | input | 1 | Active-low reset, sampled synchronously in every domain |
| cpu_src_clk | input | 1 | Source of the processor clock group |
| bus_src_clk | input | 1 | Source of the bus group and of the reference clock; qualification domain |
| aux_src_clk | input | 1 | Source of the auxiliary clock group |
| cpu_stop_n | input | 1 | Asynchronous request, low stops the processor group |
| bus_stop_n | input | 1 | Asynchronous request, low stops the gated bus group |
| pd_n | input | 1 | Asynchronous power-down, low forces every output low |
| cpu_clk_o | output | NCPU | Gated processor clocks |
| bus_clk_o | output | NBUS | Gated bus clocks |
| bus_ref_o | output | 1 | Bus reference clock, stopped only by power-down |
| aux_clk_o | output | NAUX | Auxiliary clocks, stopped only by power-down |

## Verification
The bench builds the block with four processor outputs, six bus outputs, two auxiliary outputs, two synchronizer stages and a power-up count of 40 oscillator cycles. The short count lets the bench cover the power-up hold and its release several times in one run, both after reset and after a power-down cycle. With the bench clock phases chosen so that no control change coincides with a capturing edge, the two-stage synchronizer gives a fixed number of qualifying edges. This lets the bench check the exact reference edge on which a stop or start becomes visible.

// File: rtl/clk_stop_pkg.sv
// Package: shared types for the clock stop controller.
// Assumes: the run flags are produced in the bus source clock domain.
package clk_stop_pkg;

    // Qualified run permissions, one flag per gated class of outputs.
    typedef struct packed {
        logic all_run;   // powered and settled: reference and auxiliary group
        logic cpu_run;   // powered and processor group not stopped
        logic bus_run;   // powered and bus group not stopped
    } cs_run_t;

endpackage

// File: rtl/cs_sync.sv
// Multi-stage synchronizer for a vector of independent asynchronous bits.
// Assumes STAGES >= 2 and that bits need not be coherent with each other.
// Reset value is zero, which the consumers read as "stopped / not ready".
module cs_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] pipe;

    // Shift the asynchronous inputs through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe <= '0;
        end else begin
            pipe <= {pipe[STAGES-2:0], d};
        end
    end

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/cs_pwrup_timer.sv
// Power-up hold counter in the always-on oscillator domain.
// Counts oscillator cycles while power is requested and raises ready one
// cycle after the count reaches PWRUP_CYCLES. Drops at once when power is
// withdrawn. Assumes pwr_ok is already synchronous to clk.
module cs_pwrup_timer #(
    parameter int PWRUP_CYCLES = 600000,
    parameter int CNT_W        = $clog2(PWRUP_CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_ok,
    output logic             ready,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(PWRUP_CYCLES);

    // Count up to the limit while powered, then hold and flag ready.
    always_ff @(posedge clk) begin
        if (!rst_n || !pwr_ok) begin
            cnt   <= '0;
            ready <= 1'b0;
        end else begin
            if (cnt != LIMIT) begin
                cnt <= cnt + 1'b1;
            end
            ready <= (cnt == LIMIT);
        end
    end

endmodule

// File: rtl/cs_gate_cell.sv
// Glitch-free gate for one clock output.
// The enable is sampled on the falling edge of the source, so it only
// changes while the source is low; the output is source AND enable.
// Assumes run is stable around the source falling edge (it comes from a
// flop in a domain whose edges are not aligned with this source).
module cs_gate_cell (
    input  logic src_clk,
    input  logic rst_n,
    input  logic run,
    output logic gclk
);

    logic en;

    // Update the enable only while the source is low.
    always_ff @(negedge src_clk) begin
        if (!rst_n) begin
            en <= 1'b0;
        end else begin
            en <= run;
        end
    end

    assign gclk = src_clk & en;

endmodule

// File: rtl/cs_gate_bank.sv
// A group of N gated outputs sharing one source clock and one run flag.
// Each output has its own enable flop so every pin is an independent cell.
module cs_gate_bank #(
    parameter int N = 4
) (
    input  logic         src_clk,
    input  logic         rst_n,
    input  logic         run,
    output logic [N-1:0] gclk
);

    for (genvar i = 0; i < N; i++) begin : g_cell
        cs_gate_cell u_cell (
            .src_clk (src_clk),
            .rst_n   (rst_n),
            .run     (run),
            .gclk    (gclk[i])
        );
    end

endmodule

// File: rtl/clk_stop_ctrl.sv
// Top: synchronized clock stop controller.
// Power-down is synchronized to the oscillator and timed by the power-up
// counter. The resulting ready flag and both stop requests are synchronized
// to the bus source clock and qualified on one more rising edge. Each gated
// output then applies the qualified permission on a falling edge of its own
// source. Assumes the source clocks are free-running and unrelated to the
// control inputs; rst_n is held low for several cycles of every clock.
module clk_stop_ctrl #(
    parameter int NCPU         = 4,
    parameter int NBUS         = 6,
    parameter int NAUX         = 2,
    parameter int SYNC_STAGES  = 2,
    parameter int PWRUP_CYCLES = 600000
) (
    input  logic            osc_clk,
    input  logic            rst_n,
    input  logic            cpu_src_clk,
    input  logic            bus_src_clk,
    input  logic            aux_src_clk,
    input  logic            cpu_stop_n,
    input  logic            bus_stop_n,
    input  logic            pd_n,
    output logic [NCPU-1:0] cpu_clk_o,
    output logic [NBUS-1:0] bus_clk_o,
    output logic            bus_ref_o,
    output logic [NAUX-1:0] aux_clk_o
);

    import clk_stop_pkg::*;

    localparam int CNT_W = $clog2(PWRUP_CYCLES + 1);

    logic             pd_osc;
    logic             pwr_ready;
    logic [CNT_W-1:0] pwrup_cnt;
    logic [2:0]       ref_q;
    logic             ready_ref;
    logic             cpu_go_ref;
    logic             bus_go_ref;
    cs_run_t          run_q;
    logic [0:0]       ref_bank;

    // Power-down request into the oscillator domain.
    cs_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_pd_sync (
        .clk   (osc_clk),
        .rst_n (rst_n),
        .d     (pd_n),
        .q     (pd_osc)
    );

    cs_pwrup_timer #(.PWRUP_CYCLES(PWRUP_CYCLES), .CNT_W(CNT_W)) u_timer (
        .clk    (osc_clk),
        .rst_n  (rst_n),
        .pwr_ok (pd_osc),
        .ready  (pwr_ready),
        .cnt    (pwrup_cnt)
    );

    // Ready flag and stop requests into the bus source domain.
    cs_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_ref_sync (
        .clk   (bus_src_clk),
        .rst_n (rst_n),
        .d     ({pwr_ready, bus_stop_n, cpu_stop_n}),
        .q     (ref_q)
    );

    assign ready_ref  = ref_q[2];
    assign bus_go_ref = ref_q[1];
    assign cpu_go_ref = ref_q[0];

    // Qualify the permissions on one rising edge of the reference.
    always_ff @(posedge bus_src_clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else begin
            run_q.all_run <= ready_ref;
            run_q.cpu_run <= ready_ref & cpu_go_ref;
            run_q.bus_run <= ready_ref & bus_go_ref;
        end
    end

    cs_gate_bank #(.N(NCPU)) u_cpu_bank (
        .src_clk (cpu_src_clk),
        .rst_n   (rst_n),
        .run     (run_q.cpu_run),
        .gclk    (cpu_clk_o)
    );

    cs_gate_bank #(.N(NBUS)) u_bus_bank (
        .src_clk (bus_src_clk),
        .rst_n   (rst_n),
        .run     (run_q.bus_run),
        .gclk    (bus_clk_o)
    );

    cs_gate_bank #(.N(1)) u_ref_bank (
        .src_clk (bus_src_clk),
        .rst_n   (rst_n),
        .run     (run_q.all_run),
        .gclk    (ref_bank)
    );

    cs_gate_bank #(.N(NAUX)) u_aux_bank (
        .src_clk (aux_src_clk),
        .rst_n   (rst_n),
        .run     (run_q.all_run),
        .gclk    (aux_clk_o)
    );

    assign bus_ref_o = ref_bank[0];

endmodule

// File: rtl/clk_stop_ctrl_chk.sv
// Checker for the clock stop controller: relates the power-up counter, the
// synchronized controls and the qualified run permissions over time.
module clk_stop_ctrl_chk
    import clk_stop_pkg::*;
#(
    parameter int PWRUP_CYCLES = 600000,
    parameter int CNT_W        = 20
) (
    input logic             osc_clk,
    input logic             bus_src_clk,
    input logic             rst_n,
    input logic             pd_osc,
    input logic             pwr_ready,
    input logic [CNT_W-1:0] pwrup_cnt,
    input logic             ready_ref,
    input cs_run_t          run_q
);

    // R1: reset clears the power-up state on the following edge.
    assert_reset_clears_R1: assert property (@(posedge osc_clk)
        !rst_n |=> (!pwr_ready && pwrup_cnt == '0));

    // R6: withdrawn power removes ready on the next oscillator edge.
    assert_pd_drops_ready_R6: assert property (@(posedge osc_clk) disable iff (!rst_n)
        !pd_osc |=> !pwr_ready);

    // R7: ready only appears once the full count has elapsed.
    assert_ready_after_count_R7: assert property (@(posedge osc_clk) disable iff (!rst_n)
        $rose(pwr_ready) |-> (pwrup_cnt == CNT_W'(PWRUP_CYCLES)));

    // R6: lost readiness withdraws every run permission one edge later.
    assert_not_ready_stops_all_R6: assert property (@(posedge bus_src_clk) disable iff (!rst_n)
        !ready_ref |=> (!run_q.all_run && !run_q.cpu_run && !run_q.bus_run));

    // R3: the processor group may only run while powered.
    assert_cpu_needs_power_R3: assert property (@(posedge bus_src_clk) disable iff (!rst_n)
        run_q.cpu_run |-> run_q.all_run);

    // R4: the bus group may only run while powered.
    assert_bus_needs_power_R4: assert property (@(posedge bus_src_clk) disable iff (!rst_n)
        run_q.bus_run |-> run_q.all_run);

endmodule

bind clk_stop_ctrl clk_stop_ctrl_chk #(
    .PWRUP_CYCLES (PWRUP_CYCLES),
    .CNT_W        (CNT_W)
) u_chk (
    .osc_clk     (osc_clk),
    .bus_src_clk (bus_src_clk),
    .rst_n       (rst_n),
    .pd_osc      (pd_osc),
    .pwr_ready   (pwr_ready),
    .pwrup_cnt   (pwrup_cnt),
    .ready_ref   (ready_ref),
    .run_q       (run_q)
);

// File: tb/test_clk_stop_ctrl.sv
`timescale 1ns/100ps
// Directed bench for the clock stop controller. The oscillator is the
// 200 MHz bench clock; the source clocks have periods 10, 30 and 14 ns.
// Controls change 5 ns after a bus source rising edge.
module test_clk_stop_ctrl;

    localparam int NCPU = 4;
    localparam int NBUS = 6;
    localparam int NAUX = 2;
    localparam int SYNC = 2;
    localparam int PWRUP = 40;

    logic osc_clk = 1'b0;
    logic cpu_src_clk = 1'b0;
    logic bus_src_clk = 1'b0;
    logic aux_src_clk = 1'b0;
    logic rst_n = 1'b0;
    logic cpu_stop_n = 1'b1;
    logic bus_stop_n = 1'b1;
    logic pd_n = 1'b1;
    logic [NCPU-1:0] cpu_clk_o;
    logic [NBUS-1:0] bus_clk_o;
    logic            bus_ref_o;
    logic [NAUX-1:0] aux_clk_o;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    clk_stop_ctrl #(
        .NCPU(NCPU), .NBUS(NBUS), .NAUX(NAUX),
        .SYNC_STAGES(SYNC), .PWRUP_CYCLES(PWRUP)
    ) i_clk_stop_ctrl (
        .osc_clk(osc_clk), .rst_n(rst_n),
        .cpu_src_clk(cpu_src_clk), .bus_src_clk(bus_src_clk),
        .aux_src_clk(aux_src_clk),
        .cpu_stop_n(cpu_stop_n), .bus_stop_n(bus_stop_n), .pd_n(pd_n),
        .cpu_clk_o(cpu_clk_o), .bus_clk_o(bus_clk_o),
        .bus_ref_o(bus_ref_o), .aux_clk_o(aux_clk_o)
    );

    // Clocks.
    initial forever #2.5 osc_clk = ~osc_clk;
    initial forever #5 cpu_src_clk = ~cpu_src_clk;
    initial begin #2; forever #15 bus_src_clk = ~bus_src_clk; end
    initial forever #7 aux_src_clk = ~aux_src_clk;

    // Rising-edge counters and pulse-width / group-coherence monitors.
    int cpu_r = 0, bus_r = 0, ref_r = 0, aux_r = 0;
    int width_bad = 0, group_bad = 0;
    realtime cpu_t0, bus_t0, ref_t0, aux_t0;

    function automatic bit width_off(realtime w, realtime exp);
        return (w < exp - 0.05) || (w > exp + 0.05);
    endfunction

    always @(posedge cpu_clk_o[0]) begin cpu_r++; cpu_t0 = $realtime; end
    always @(posedge bus_clk_o[0]) begin bus_r++; bus_t0 = $realtime; end
    always @(posedge bus_ref_o)    begin ref_r++; ref_t0 = $realtime; end
    always @(posedge aux_clk_o[0]) begin aux_r++; aux_t0 = $realtime; end
    always @(negedge cpu_clk_o[0]) if (width_off($realtime - cpu_t0, 5.0))  width_bad++;
    always @(negedge bus_clk_o[0]) if (width_off($realtime - bus_t0, 15.0)) width_bad++;
    always @(negedge bus_ref_o)    if (width_off($realtime - ref_t0, 15.0)) width_bad++;
    always @(negedge aux_clk_o[0]) if (width_off($realtime - aux_t0, 7.0))  width_bad++;
    always @(cpu_clk_o) if (cpu_clk_o != '0 && cpu_clk_o != '1) group_bad++;
    always @(bus_clk_o) if (bus_clk_o != '0 && bus_clk_o != '1) group_bad++;
    always @(aux_clk_o) if (aux_clk_o != '0 && aux_clk_o != '1) group_bad++;

    task automatic check(input string req, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // R1: outputs held low during reset.
    task automatic t_reset();
        #90;
        check("R1", "rises during reset", cpu_r + bus_r + ref_r + aux_r, 0);
        check("R1", "outputs during reset",
              int'(|cpu_clk_o | |bus_clk_o | bus_ref_o | |aux_clk_o), 0);
    endtask

    // R7: power-up hold after reset release, then all groups run.
    task automatic t_powerup();
        int c, b, r, a;
        #11 rst_n = 1'b1;
        #195;
        check("R7", "rises inside power-up hold", cpu_r + bus_r + ref_r + aux_r, 0);
        #300;
        c = cpu_r; b = bus_r; r = ref_r; a = aux_r;
        #100;
        check("R7", "cpu running after hold", int'(cpu_r > c), 1);
        check("R7", "bus running after hold", int'(bus_r > b), 1);
        check("R7", "ref running after hold", int'(ref_r > r), 1);
        check("R7", "aux running after hold", int'(aux_r > a), 1);
    endtask

    // R3/R5: processor stop and restart latency; others unaffected.
    task automatic t_cpu_stop();
        int c, b, r, a;
        @(posedge bus_src_clk); #5 cpu_stop_n = 1'b0;
        repeat (SYNC) @(posedge bus_src_clk);
        #1 c = cpu_r;
        #20 check("R3", "cpu still running before qualify", int'(cpu_r > c), 1);
        #20;
        c = cpu_r; b = bus_r; r = ref_r; a = aux_r;
        #100;
        check("R3", "cpu rises while stopped", cpu_r - c, 0);
        check("R3", "cpu level while stopped", int'(|cpu_clk_o), 0);
        check("R5", "bus runs during cpu stop", int'(bus_r > b), 1);
        check("R5", "ref runs during cpu stop", int'(ref_r > r), 1);
        check("R5", "aux runs during cpu stop", int'(aux_r > a), 1);
        @(posedge bus_src_clk); #5 cpu_stop_n = 1'b1;
        repeat (SYNC) @(posedge bus_src_clk);
        #1 c = cpu_r;
        #20 check("R3", "cpu still stopped before qualify", cpu_r - c, 0);
        #20 c = cpu_r;
        #100 check("R3", "cpu restarted", int'(cpu_r > c), 1);
    endtask

    // R4/R5: bus stop and restart latency; reference and others unaffected.
    task automatic t_bus_stop();
        int c, b, r, a;
        @(posedge bus_src_clk); #5 bus_stop_n = 1'b0;
        repeat (SYNC) @(posedge bus_src_clk);
        #1 b = bus_r;
        #31 check("R4", "bus pulse on qualifying edge", int'(bus_r > b), 1);
        #15;
        c = cpu_r; b = bus_r; r = ref_r; a = aux_r;
        #100;
        check("R4", "bus rises while stopped", bus_r - b, 0);
        check("R4", "bus level while stopped", int'(|bus_clk_o), 0);
        check("R5", "ref runs during bus stop", int'(ref_r > r), 1);
        check("R5", "cpu runs during bus stop", int'(cpu_r > c), 1);
        check("R5", "aux runs during bus stop", int'(aux_r > a), 1);
        @(posedge bus_src_clk); #5 bus_stop_n = 1'b1;
        repeat (SYNC) @(posedge bus_src_clk);
        #1 b = bus_r;
        #28 check("R4", "bus still stopped before qualify", bus_r - b, 0);
        #20 b = bus_r;
        #100 check("R4", "bus restarted", int'(bus_r > b), 1);
    endtask

    // R6/R7: power-down overrides released stops; power-up hold again.
    task automatic t_power_down();
        int c, b, r, a;
        @(posedge bus_src_clk); #5 pd_n = 1'b0;
        #300;
        c = cpu_r; b = bus_r; r = ref_r; a = aux_r;
        #200;
        check("R6", "cpu rises in power-down", cpu_r - c, 0);
        check("R6", "bus rises in power-down", bus_r - b, 0);
        check("R6", "ref rises in power-down", ref_r - r, 0);
        check("R6", "aux rises in power-down", aux_r - a, 0);
        check("R6", "levels in power-down",
              int'(|cpu_clk_o | |bus_clk_o | bus_ref_o | |aux_clk_o), 0);
        @(posedge bus_src_clk); #5 pd_n = 1'b1;
        c = cpu_r; b = bus_r; r = ref_r; a = aux_r;
        #195;
        check("R7", "rises inside hold after power-down",
              (cpu_r - c) + (bus_r - b) + (ref_r - r) + (aux_r - a), 0);
        #300;
        c = cpu_r; b = bus_r; r = ref_r; a = aux_r;
        #100;
        check("R7", "all groups back after hold",
              int'(cpu_r > c && bus_r > b && ref_r > r && aux_r > a), 1);
    endtask

    // R2: pulse widths and group coherence over the whole run.
    task automatic t_waveform();
        check("R2", "short or long high pulses", width_bad, 0);
        check("R2", "incoherent group bits", group_bad, 0);
    endtask

    initial begin
        t_reset();
        t_powerup();
        t_cpu_stop();
        t_bus_stop();
        t_power_down();
        t_waveform();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #500000;
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule